// File: doc/BRIEF.md
# DVFS Operating-Point Sequencer

This block chooses a clock-frequency and supply-voltage operating point for a compute fabric whose load changes over time. A workload request carries the required real-time clock rate in MHz, together with a descriptor of the load: the active user count and the decoder constraint length. The block looks up a fixed table of five operating points. It picks the slowest point that still meets the required rate. It then moves the chip to that point through two handshakes, one to the supply regulator and one to the clock generator.

The change is always ordered so that the clock never runs faster than the supply in force allows. When the point rises, the voltage goes up first. The block then waits a programmable settling time and only after that raises the clock. When the point falls, the clock drops first and the voltage follows, again with a settling wait. Transitions are meant to be rare. A minimum-interval timer therefore keeps a new transition from starting too soon after the last one finished. Requests that arrive while the block is busy or blocked are held, and only the newest one is kept.

Top module: `opp_sequencer`

## Requirements
- R1: After reset the reported point is 433 MHz / 875 mV. The reported workload is users code 0 and length code 0. `busy` is low and neither command is asserted.
- R2: The table, by index code, is 0: 433 MHz / 875 mV, 1: 533 MHz / 950 mV, 2: 667 MHz / 1050 mV, 3: 1000 MHz / 1300 mV and 4: 1200 MHz / 1400 mV. A request selects the lowest index whose frequency is at least `req_mhz`. The index is the code sent on both command buses.
- R3: A `req_mhz` above 1200 selects index 4.
- R4: When the target index is above the current one, the voltage command is issued and acknowledged first. The clock command comes only after that, so a raised clock code always equals the voltage code already acknowledged.
- R5: When the target index is below the current one, the clock command is issued and acknowledged first. The voltage command follows with the same code.
- R6: After each voltage acknowledge the block waits at least N cycles before its next step, which is the clock command or completion. N is `settle_cycles` clamped to the range 100 to 1000.
- R7: A new transition does not start until at least `MIN_GAP` cycles after the previous transition completed. A request that arrives earlier waits.
- R8: Requests that arrive while a transition is running or blocked are latched. Only the most recent one is applied.
- R9: `busy` is high from the cycle after a transition starts until the cycle after completion. The reported point changes only at completion.
- R10: A request whose selected index equals the current one completes at once, even inside the minimum interval. No command is issued and `busy` stays low.
- R11: The users code (0: 4, 1: 8, 2: 16, 3: 32 users) and the length code (0: 7, 1: 9) of a request are reported on `act_users` and `act_klen` when that request is applied.
- R12: The frequency index acknowledged by the clock generator never exceeds the voltage index acknowledged by the regulator.
- R13: Each command stays asserted with a stable code until its acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle workload request strobe |
| req_users | input | 2 | Users code of the request |
| req_klen | input | 1 | Constraint-length code of the request |
| req_mhz | input | 11 | Required real-time frequency in MHz |
| settle_cycles | input | 10 | Regulator settling wait, clamped to 100..1000 |
| vreg_cmd_valid | output | 1 | Voltage command request |
| vreg_cmd_code | output | 3 | Target operating-point index for the regulator |
| vreg_ack | input | 1 | Regulator acknowledge |
| clk_cmd_valid | output | 1 | Clock command request |
| clk_cmd_code | output | 3 | Target operating-point index for the clock generator |
| clk_ack | input | 1 | Clock generator acknowledge |
| busy | output | 1 | Transition in progress |
| cur_mhz | output | 11 | Frequency of the stable point in MHz |
| cur_mv | output | 11 | Voltage of the stable point in mV |
| act_users | output | 2 | Users code of the applied workload |
| act_klen | output | 1 | Constraint-length code of the applied workload |

## Verification
The hardest situation to reach is a burst of requests that lands while a transition is already running and the minimum interval is about to block the next one. In that case the latched request must be replaced, not queued, and must wait out the interval before it moves the point down. The bench fires a rising request, waits until `busy` is seen, and then sends two more requests with different targets in quick succession. A behavioural model, run in step with the design, predicts every command, acknowledge-driven step and settling count on every clock. Both settling clamp limits are reached by driving `settle_cycles` below 100 and above 1000.

// File: rtl/opp_pkg.sv
package opp_pkg;
  localparam int NUM_OPP  = 5;
  localparam int IDX_W    = $clog2(NUM_OPP);
  localparam int MHZ_W    = 11;
  localparam int MV_W     = 11;
  localparam int SETTLE_W = 10;
  localparam int SETTLE_MIN = 100;
  localparam int SETTLE_MAX = 1000;

  typedef logic [IDX_W-1:0] opp_idx_t;

  typedef enum logic [2:0] {
    S_IDLE, S_VUP, S_VUP_WAIT, S_FUP, S_FDN, S_VDN, S_VDN_WAIT, S_FIN
  } seq_state_t;

  // frequency of each operating point, ascending
  function automatic logic [MHZ_W-1:0] opp_mhz(opp_idx_t i);
    case (i)
      3'd0: opp_mhz = MHZ_W'(433);
      3'd1: opp_mhz = MHZ_W'(533);
      3'd2: opp_mhz = MHZ_W'(667);
      3'd3: opp_mhz = MHZ_W'(1000);
      default: opp_mhz = MHZ_W'(1200);
    endcase
  endfunction

  function automatic logic [MV_W-1:0] opp_mv(opp_idx_t i);
    case (i)
      3'd0: opp_mv = MV_W'(875);
      3'd1: opp_mv = MV_W'(950);
      3'd2: opp_mv = MV_W'(1050);
      3'd3: opp_mv = MV_W'(1300);
      default: opp_mv = MV_W'(1400);
    endcase
  endfunction

  // lowest index whose frequency covers the need; top index if none does
  function automatic opp_idx_t opp_pick(logic [MHZ_W-1:0] need);
    opp_idx_t best;
    best = opp_idx_t'(NUM_OPP - 1);
    for (int i = NUM_OPP - 1; i >= 0; i--) begin
      if (opp_mhz(opp_idx_t'(i)) >= need) best = opp_idx_t'(i);
    end
    return best;
  endfunction

  function automatic logic [SETTLE_W-1:0] settle_clamp(logic [SETTLE_W-1:0] n);
    if (n < SETTLE_W'(SETTLE_MIN))      settle_clamp = SETTLE_W'(SETTLE_MIN);
    else if (n > SETTLE_W'(SETTLE_MAX)) settle_clamp = SETTLE_W'(SETTLE_MAX);
    else                                settle_clamp = n;
  endfunction
endpackage

// File: rtl/opp_select.sv
module opp_select import opp_pkg::*; (
  input  logic [MHZ_W-1:0] need_mhz,
  output opp_idx_t         pick
);
  always_comb pick = opp_pick(need_mhz);

  // R2: chosen point covers the need, and the next lower one does not
  always_comb begin
    if (need_mhz <= opp_mhz(opp_idx_t'(NUM_OPP - 1))) begin
      p_pick_covers_r2: assert (opp_mhz(pick) >= need_mhz);
      if (pick != '0) begin
        p_pick_lowest_r2: assert (opp_mhz(pick - opp_idx_t'(1)) < need_mhz);
      end
    end else begin
      p_pick_clamp_r3: assert (pick == opp_idx_t'(NUM_OPP - 1));
    end
  end
endmodule

// File: rtl/opp_countdown.sv
module opp_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/opp_sequencer.sv
module opp_sequencer import opp_pkg::*; #(
  parameter int unsigned MIN_GAP = 1_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_users,
  input  logic                req_klen,
  input  logic [MHZ_W-1:0]    req_mhz,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                vreg_cmd_valid,
  output logic [IDX_W-1:0]    vreg_cmd_code,
  input  logic                vreg_ack,
  output logic                clk_cmd_valid,
  output logic [IDX_W-1:0]    clk_cmd_code,
  input  logic                clk_ack,
  output logic                busy,
  output logic [MHZ_W-1:0]    cur_mhz,
  output logic [MV_W-1:0]     cur_mv,
  output logic [1:0]          act_users,
  output logic                act_klen
);
  localparam int GAP_W = $clog2(MIN_GAP + 1) < 1 ? 1 : $clog2(MIN_GAP + 1);

  seq_state_t st, st_nx;
  opp_idx_t   req_idx, pend_idx, cur_idx, tgt_idx;
  opp_idx_t   v_applied, f_applied;
  logic       pend_v;
  logic [1:0] pend_users, tgt_users;
  logic       pend_klen, tgt_klen;

  // named internal events
  logic same_hit, tr_start, tr_done, consume;
  logic settle_load, settle_zero, gap_zero;
  logic v_acked, f_acked;

  opp_select u_sel (
    .need_mhz (req_mhz),
    .pick     (req_idx)
  );

  opp_countdown #(.W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (settle_load),
    .load_val (settle_clamp(settle_cycles)),
    .zero     (settle_zero)
  );

  opp_countdown #(.W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tr_done),
    .load_val (GAP_W'(MIN_GAP)),
    .zero     (gap_zero)
  );

  assign same_hit    = (st == S_IDLE) && pend_v && (pend_idx == cur_idx);
  assign tr_start    = (st == S_IDLE) && pend_v && (pend_idx != cur_idx) && gap_zero;
  assign tr_done     = (st == S_FIN);
  assign consume     = same_hit || tr_start;
  assign v_acked     = vreg_ack && vreg_cmd_valid;
  assign f_acked     = clk_ack && clk_cmd_valid;
  assign settle_load = v_acked;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:     if (tr_start) st_nx = (pend_idx > cur_idx) ? S_VUP : S_FDN;
      S_VUP:      if (vreg_ack) st_nx = S_VUP_WAIT;
      S_VUP_WAIT: if (settle_zero) st_nx = S_FUP;
      S_FUP:      if (clk_ack) st_nx = S_FIN;
      S_FDN:      if (clk_ack) st_nx = S_VDN;
      S_VDN:      if (vreg_ack) st_nx = S_VDN_WAIT;
      S_VDN_WAIT: if (settle_zero) st_nx = S_FIN;
      S_FIN:      st_nx = S_IDLE;
      default:    st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pend_v     <= 1'b0;
      pend_idx   <= '0;
      pend_users <= '0;
      pend_klen  <= 1'b0;
      cur_idx    <= '0;
      tgt_idx    <= '0;
      tgt_users  <= '0;
      tgt_klen   <= 1'b0;
      act_users  <= '0;
      act_klen   <= 1'b0;
      v_applied  <= '0;
      f_applied  <= '0;
    end else begin
      st <= st_nx;
      // newest request always overwrites the latch
      if (req_valid) begin
        pend_v     <= 1'b1;
        pend_idx   <= req_idx;
        pend_users <= req_users;
        pend_klen  <= req_klen;
      end else if (consume) begin
        pend_v <= 1'b0;
      end
      if (same_hit) begin
        act_users <= pend_users;
        act_klen  <= pend_klen;
      end
      if (tr_start) begin
        tgt_idx   <= pend_idx;
        tgt_users <= pend_users;
        tgt_klen  <= pend_klen;
      end
      if (tr_done) begin
        cur_idx   <= tgt_idx;
        act_users <= tgt_users;
        act_klen  <= tgt_klen;
      end
      if (v_acked) v_applied <= tgt_idx;
      if (f_acked) f_applied <= tgt_idx;
    end
  end

  assign vreg_cmd_valid = (st == S_VUP) || (st == S_VDN);
  assign clk_cmd_valid  = (st == S_FUP) || (st == S_FDN);
  assign vreg_cmd_code  = tgt_idx;
  assign clk_cmd_code   = tgt_idx;
  assign busy           = (st != S_IDLE);
  assign cur_mhz        = opp_mhz(cur_idx);
  assign cur_mv         = opp_mv(cur_idx);

  // R12: clock never ahead of the supply
  p_freq_under_volt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    f_applied <= v_applied);

  // R13: commands held with stable code until acknowledged
  p_vcmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_cmd_valid && !vreg_ack) |=> (vreg_cmd_valid && $stable(vreg_cmd_code)));
  p_ccmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_cmd_valid && !clk_ack) |=> (clk_cmd_valid && $stable(clk_cmd_code)));

  // R4: a rising clock command only targets a voltage already in place
  p_up_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_cmd_valid && (clk_cmd_code > f_applied)) |-> (v_applied == clk_cmd_code));

  // R5: a falling voltage command only follows a clock already lowered
  p_down_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_cmd_valid && (vreg_cmd_code < v_applied)) |-> (f_applied == vreg_cmd_code));

  // R7: a transition begins only once the interval timer has expired
  p_gap_respected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(gap_zero));

  // R9: the reported point moves only out of the completion step
  p_point_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> $past(st == S_FIN));

  // R10: no command outside a transition
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(vreg_cmd_valid || clk_cmd_valid));
endmodule

// File: tb/tb_opp_sequencer.sv
module tb_opp_sequencer;
  localparam int GAP = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_users = '0;
  logic        req_klen = 1'b0;
  logic [10:0] req_mhz = '0;
  logic [9:0]  settle_cycles = 10'd40;
  logic        vreg_cmd_valid, clk_cmd_valid, vreg_ack = 1'b0, clk_ack = 1'b0;
  logic [2:0]  vreg_cmd_code, clk_cmd_code;
  logic        busy, act_klen;
  logic [10:0] cur_mhz, cur_mv;
  logic [1:0]  act_users;

  always #5 clk = ~clk;

  opp_sequencer #(.MIN_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_users(req_users),
    .req_klen(req_klen), .req_mhz(req_mhz), .settle_cycles(settle_cycles),
    .vreg_cmd_valid(vreg_cmd_valid), .vreg_cmd_code(vreg_cmd_code), .vreg_ack(vreg_ack),
    .clk_cmd_valid(clk_cmd_valid), .clk_cmd_code(clk_cmd_code), .clk_ack(clk_ack),
    .busy(busy), .cur_mhz(cur_mhz), .cur_mv(cur_mv),
    .act_users(act_users), .act_klen(act_klen));

  int n_chk = 0, n_fail = 0;
  int mhz_tab [5] = '{433, 533, 667, 1000, 1200};
  int mv_tab  [5] = '{875, 950, 1050, 1300, 1400};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pick_of(input int need);
    for (int i = 0; i < 5; i++) if (mhz_tab[i] >= need) return i;
    return 4;
  endfunction

  function automatic int clampn(input int n);
    return (n < 100) ? 100 : (n > 1000) ? 1000 : n;
  endfunction

  // ---------------- reference model (phase numbers: 0 idle, 1 volt up,
  // 2 settle up, 3 clock up, 4 clock down, 5 volt down, 7 settle down, 6 finish)
  int m_ph, m_pv, m_pidx, m_pu, m_pk, m_cur, m_tgt, m_tu, m_tk, m_au, m_ak, m_gap, m_set;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pv = 0; m_pidx = 0; m_pu = 0; m_pk = 0; m_cur = 0; m_tgt = 0;
      m_tu = 0; m_tk = 0; m_au = 0; m_ak = 0; m_gap = 0; m_set = 0;
    end else begin
      automatic int og = m_gap, os = m_set, nph = m_ph;
      automatic bit took = 0, sload = 0;
      case (m_ph)
        0: if (m_pv && m_pidx == m_cur) begin took = 1; m_au = m_pu; m_ak = m_pk; end
           else if (m_pv && og == 0) begin
             took = 1; m_tgt = m_pidx; m_tu = m_pu; m_tk = m_pk;
             nph = (m_pidx > m_cur) ? 1 : 4;
           end
        1: if (vreg_ack) begin nph = 2; sload = 1; end
        2: if (os == 0) nph = 3;
        3: if (clk_ack) nph = 6;
        4: if (clk_ack) nph = 5;
        5: if (vreg_ack) begin nph = 7; sload = 1; end
        7: if (os == 0) nph = 6;
        6: begin m_cur = m_tgt; m_au = m_tu; m_ak = m_tk; nph = 0; end
        default: nph = 0;
      endcase
      if (m_ph == 6) m_gap = GAP; else if (og > 0) m_gap = og - 1;
      if (sload) m_set = clampn(settle_cycles); else if (os > 0) m_set = os - 1;
      if (req_valid) begin
        m_pv = 1; m_pidx = pick_of(req_mhz); m_pu = req_users; m_pk = req_klen;
      end else if (took) m_pv = 0;
      m_ph = nph;
    end
  end

  // ---------------- regulator and clock generator responders
  int vcnt = 0, ccnt = 0;
  always @(posedge clk) begin
    #2;
    if (vreg_cmd_valid) vcnt++; else vcnt = 0;
    if (clk_cmd_valid)  ccnt++; else ccnt = 0;
    vreg_ack = vreg_cmd_valid && vcnt >= 3;
    clk_ack  = clk_cmd_valid && ccnt >= 5;
  end

  // ---------------- per-cycle compare and protocol monitors
  int cyc = 0, last_done = -1, vack_cyc = -1, vack_n = 0;
  int v_code_acked = 0, f_code_acked = 0;
  bit prev_busy = 0, prev_cv = 0, busy_seen = 0, cmd_seen = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      automatic bit e_v = (m_ph == 1 || m_ph == 5);
      automatic bit e_c = (m_ph == 3 || m_ph == 4);
      chk(busy == (m_ph != 0), "R9 busy", busy, m_ph != 0);
      chk(vreg_cmd_valid == e_v, "R4 R5 voltage command", vreg_cmd_valid, e_v);
      chk(clk_cmd_valid == e_c, "R4 R5 clock command", clk_cmd_valid, e_c);
      if (e_v) chk(vreg_cmd_code == m_tgt, "R13 voltage code", vreg_cmd_code, m_tgt);
      if (e_c) chk(clk_cmd_code == m_tgt, "R13 clock code", clk_cmd_code, m_tgt);
      chk(cur_mhz == mhz_tab[m_cur], "R2 cur_mhz", cur_mhz, mhz_tab[m_cur]);
      chk(cur_mv == mv_tab[m_cur], "R2 cur_mv", cur_mv, mv_tab[m_cur]);
      chk(act_users == m_au, "R11 users", act_users, m_au);
      chk(act_klen == m_ak, "R11 klen", act_klen, m_ak);
      if (busy) busy_seen = 1;
      if (vreg_cmd_valid || clk_cmd_valid) cmd_seen = 1;
      // R7 interval from completion to next start
      if (busy && !prev_busy && last_done >= 0)
        chk(cyc - last_done >= GAP, "R7 interval", cyc - last_done, GAP);
      // R6 settling after voltage acknowledge
      if (vack_cyc >= 0 && ((clk_cmd_valid && !prev_cv) || (!busy && prev_busy))) begin
        chk(cyc - vack_cyc >= vack_n, "R6 settle", cyc - vack_cyc, vack_n);
        vack_cyc = -1;
      end
      if (!busy && prev_busy) last_done = cyc;
      if (vreg_ack && vreg_cmd_valid) begin
        vack_cyc = cyc; vack_n = clampn(settle_cycles); v_code_acked = vreg_cmd_code;
      end
      if (clk_ack && clk_cmd_valid) begin
        chk(clk_cmd_code <= v_code_acked, "R12 freq under volt", clk_cmd_code, v_code_acked);
        f_code_acked = clk_cmd_code;
      end
      prev_busy = busy; prev_cv = clk_cmd_valid;
    end
  end

  // ---------------- stimulus
  task automatic send(input int mhz, input int u, input int k);
    @(negedge clk);
    req_valid = 1'b1; req_mhz = 11'(mhz); req_users = 2'(u); req_klen = 1'(k);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (m_ph == 0 && m_pv == 0) return;
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cur_mhz == 433 && cur_mv == 875, "R1 reset point", cur_mhz, 433);
    chk(!busy && !vreg_cmd_valid && !clk_cmd_valid, "R1 reset idle", busy, 0);
    chk(act_users == 0 && act_klen == 0, "R1 reset workload", act_users, 0);

    // R10 same point: 345 MHz maps to index 0
    busy_seen = 0; cmd_seen = 0;
    send(345, 1, 0);
    repeat (3) @(negedge clk);
    chk(!busy_seen && !cmd_seen, "R10 no transition", busy_seen, 0);
    chk(act_users == 1, "R10 R11 workload applied", act_users, 1);

    // R2 R4 raise to 1000 MHz, settle clamped up to 100 (R6)
    send(902, 2, 1);
    wait_quiet();
    chk(cur_mhz == 1000 && cur_mv == 1300, "R2 R4 raise point", cur_mhz, 1000);
    chk(act_users == 2 && act_klen == 1, "R11 workload", act_users, 2);

    // R5 R7 immediate lowering must wait for the interval
    send(500, 3, 0);
    wait_quiet();
    chk(cur_mhz == 533, "R5 R7 lowered point", cur_mhz, 533);

    // R8 newest latched request wins
    send(1300, 0, 0);
    while (!busy) @(negedge clk);
    send(300, 1, 1);
    send(640, 2, 1);
    wait_quiet();
    chk(cur_mhz == 1200 || cur_mhz == 667, "R8 progressed", cur_mhz, 667);
    chk(cur_mhz == 667 && act_users == 2, "R8 latest applied", cur_mhz, 667);

    // R3 above table top, settle clamped down to 1000 (R6)
    settle_cycles = 10'd1023;
    send(2000, 3, 1);
    wait_quiet();
    chk(cur_mhz == 1200 && cur_mv == 1400, "R3 clamp to top", cur_mhz, 1200);

    // R2 boundaries: exact table value and one above
    settle_cycles = 10'd250;
    send(433, 0, 0);
    wait_quiet();
    chk(cur_mhz == 433, "R2 exact boundary", cur_mhz, 433);
    send(434, 1, 0);
    wait_quiet();
    chk(cur_mhz == 533 && cur_mv == 950, "R2 just above boundary", cur_mhz, 533);
    chk(f_code_acked == 1 && v_code_acked == 1, "R12 final codes", f_code_acked, 1);

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule